// File: doc/BRIEF.md
# Outage Relay Transfer Sequencer

This block supervises an active-low mains-presence input, sampled by a slow (nominally 32 kHz) clock, and sequences a relay pair from it. The raw input is asynchronous, so it first passes through a chain of flip-flops. Only the output of that chain is used. A change of level is acted on only after the synchronized input has held the new level for a full qualification window. The default window is 160000 cycles, which is 5 s at 32 kHz. When a loss qualifies, the block emits a one-cycle open trigger for the primary relay and raises the transfer-switch level for the secondary relay. When the return of the input qualifies, it emits a one-cycle shut trigger and drops the transfer switch.

Any sample of the old level during a qualification window abandons that window. The count then starts again from zero, so a noisy line never reaches the relays. The sequencer has four states:

- `ST_NORMAL`: mains present.
- `ST_QUAL_LOSS`: a loss is being timed.
- `ST_BACKUP`: the loss has been committed.
- `ST_QUAL_RET`: a return is being timed.

The transitions are:

- *loss_seen*: `ST_NORMAL` to `ST_QUAL_LOSS`.
- *loss_abort*: `ST_QUAL_LOSS` to `ST_NORMAL`.
- *loss_commit*: `ST_QUAL_LOSS` to `ST_BACKUP`.
- *ret_seen*: `ST_BACKUP` to `ST_QUAL_RET`.
- *ret_abort*: `ST_QUAL_RET` to `ST_BACKUP`.
- *ret_commit*: `ST_QUAL_RET` to `ST_NORMAL`.

The state code is brought out as a two-bit phase indication.

Top module: `outage_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, open_trig_o, shut_trig_o and xfer_o are 0 and phase_o is 2'b00 (mains present), until the input changes.
- R2: The FSM sees mains_ok_n_i through exactly two flip-flops. A level driven before rising edge e changes phase_o first after edge e+2.
- R3: When the synchronized input has been 0 on HOLD_CYCLES consecutive edges while in normal operation, open_trig_o is 1 for the following cycle and xfer_o rises in that same cycle.
- R4: When the synchronized input has been 1 on HOLD_CYCLES consecutive edges while on backup, shut_trig_o is 1 for the following cycle and xfer_o falls in that same cycle.
- R5: A single sample of the old level during qualification returns phase_o to the committed value (2'b00 or 2'b10) with no trigger pulse. A run of HOLD_CYCLES-1 samples therefore never switches the relays.
- R6: open_trig_o and shut_trig_o are each high for exactly one cycle and are never high in the same cycle.
- R7: phase_o encodes the state as follows: bit 1 = 1 when the loss is committed (backup), bit 0 = 1 while a change is being qualified. So 00 = normal, 01 = qualifying loss, 10 = backup, 11 = qualifying return. Bit 1 always equals xfer_o.
- R8: xfer_o rises only in a cycle with open_trig_o high and falls only in a cycle with shut_trig_o high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mains_ok_n_i | input | 1 | Asynchronous outage detect: 0 = lost, 1 = present |
| open_trig_o | output | 1 | One-cycle pulse that opens the primary relay |
| shut_trig_o | output | 1 | One-cycle pulse that shuts the primary relay |
| xfer_o | output | 1 | Secondary transfer relay level, 1 = on backup |
| phase_o | output | 2 | Sequencer phase indication (see R7) |

## Verification
The interesting collision is a qualification that is about to complete meeting a sample of the old level. The commit and abort decisions then compete in the same cycle of the qualifying state. The bench provokes this with input runs of exactly HOLD_CYCLES-1 and exactly HOLD_CYCLES samples, and with one-cycle glitches placed in the middle of both loss and return windows. A behavioural streak-count model decides on every clock whether a trigger is due, and the triggers, xfer_o and phase_o are compared against it. The bench also checks that no pulse ever appears on an abandoned window.

// File: rtl/outage_seq_pkg.sv
package outage_seq_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'b00,
        ST_QUAL_LOSS = 2'b01,
        ST_BACKUP    = 2'b10,
        ST_QUAL_RET  = 2'b11
    } seq_state_t;

endpackage

// File: rtl/outage_sync.sv
module outage_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

    // R2: the output follows the first stage one edge later
    p_chain_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2) |=> sync_o == $past(chain_q[0]));
endmodule

// File: rtl/outage_hold_timer.sv
module outage_hold_timer #(
    parameter int HOLD_CYCLES = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] DONE_AT = CW'(HOLD_CYCLES - 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run_i)            cnt_q <= '0;
        else if (cnt_q != DONE_AT)  cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == DONE_AT);

    // R3: an uninterrupted window advances by one sample per edge
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !done_o) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R5: a broken window leaves the count at zero
    p_count_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/outage_xfer_seq.sv
module outage_xfer_seq
    import outage_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 160000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mains_ok_n_i,
    output logic       open_trig_o,
    output logic       shut_trig_o,
    output logic       xfer_o,
    output logic [1:0] phase_o
);
    seq_state_t state_q, state_d;
    logic       mains_s;
    logic       run;
    logic       done;
    logic       open_q, shut_q, xfer_q;

    outage_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mains_ok_n_i),
        .sync_o  (mains_s)
    );

    assign run = ((state_q == ST_QUAL_LOSS) && !mains_s) ||
                 ((state_q == ST_QUAL_RET)  &&  mains_s);

    outage_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .done_o (done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:    if (!mains_s) state_d = ST_QUAL_LOSS;      // loss_seen
            ST_QUAL_LOSS: if (mains_s)  state_d = ST_NORMAL;         // loss_abort
                          else if (done) state_d = ST_BACKUP;        // loss_commit
            ST_BACKUP:    if (mains_s)  state_d = ST_QUAL_RET;       // ret_seen
            ST_QUAL_RET:  if (!mains_s) state_d = ST_BACKUP;         // ret_abort
                          else if (done) state_d = ST_NORMAL;        // ret_commit
            default:      state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            shut_q <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            open_q <= (state_q == ST_QUAL_LOSS) && !mains_s && done;
            shut_q <= (state_q == ST_QUAL_RET)  &&  mains_s && done;
            if ((state_q == ST_QUAL_LOSS) && !mains_s && done) xfer_q <= 1'b1;
            else if ((state_q == ST_QUAL_RET) && mains_s && done) xfer_q <= 1'b0;
        end
    end

    assign open_trig_o = open_q;
    assign shut_trig_o = shut_q;
    assign xfer_o      = xfer_q;
    assign phase_o     = state_q;

    p_trig_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_q && shut_q));
    p_open_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |=> !open_q);
    p_shut_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shut_q |=> !shut_q);
    p_xfer_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_q) |-> open_q);
    p_xfer_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_q) |-> shut_q);
    p_phase_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[1] == xfer_q);
    p_loss_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL_LOSS && mains_s) |=> (state_q == ST_NORMAL && !open_q));
    p_ret_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL_RET && !mains_s) |=> (state_q == ST_BACKUP && !shut_q));
endmodule

// File: tb/outage_xfer_seq_tb.sv
`timescale 1ns/1ps
module outage_xfer_seq_tb;
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mains_n = 1'b1;
    logic       open_t, shut_t, xfer;
    logic [1:0] phase;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit q1 = 1'b1, q2 = 1'b1;
    bit m_backup = 1'b0;
    int m_streak = 0;
    bit m_open = 1'b0, m_shut = 1'b0;
    bit compare_on = 1'b0;
    int opens_seen = 0;

    always #2.5 clk = ~clk;

    outage_xfer_seq #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mains_ok_n_i (mains_n),
        .open_trig_o  (open_t),
        .shut_trig_o  (shut_t),
        .xfer_o       (xfer),
        .phase_o      (phase)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // reference model: streak of synchronized samples differing from the committed level
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q1 = 1'b1; q2 = 1'b1; m_backup = 1'b0; m_streak = 0;
            m_open = 1'b0; m_shut = 1'b0;
        end else begin
            bit s;
            s = q2;
            m_open = 1'b0;
            m_shut = 1'b0;
            if (s == m_backup) begin
                m_streak++;
                if (m_streak == HOLD) begin
                    m_streak = 0;
                    if (!m_backup) m_open = 1'b1; else m_shut = 1'b1;
                    m_backup = ~m_backup;
                end
            end else begin
                m_streak = 0;
            end
            q2 = q1;
            q1 = mains_n;
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            check("R3", "open_trig_o", open_t, m_open);
            check("R4", "shut_trig_o", shut_t, m_shut);
            check("R8", "xfer_o", xfer, m_backup);
            check("R7", "phase_o", phase, {m_backup, (m_streak > 0)});
            check("R6", "trigger overlap", open_t & shut_t, 0);
            if (open_t) opens_seen++;
        end
    end

    task automatic hold_level(input bit lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mains_n = lvl;
        end
    endtask

    initial begin
        // watchdog
        while (!done && cycles < 200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "open in reset", open_t, 0);
        check("R1", "xfer in reset", xfer, 0);
        check("R1", "phase in reset", phase, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "phase after reset", phase, 0);
        check("R1", "shut after reset", shut_t, 0);

        // R2: latency through the two-flop chain
        mains_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2", "phase before third edge", phase, 0);
        @(posedge clk); @(negedge clk);
        check("R2", "phase after third edge", phase, 1);

        // R3: long loss commits
        hold_level(1'b0, 3 * HOLD);
        check("R3", "xfer after loss", xfer, 1);
        check("R7", "phase on backup", phase, 2);
        check("R3", "one open pulse", opens_seen, 1);

        // R5: glitch in return window
        hold_level(1'b1, HOLD / 2);
        hold_level(1'b0, 1);
        hold_level(1'b0, 4);
        check("R5", "phase after return glitch", phase, 2);
        check("R5", "xfer held after glitch", xfer, 1);

        // R4: return commits
        hold_level(1'b1, 3 * HOLD);
        check("R4", "xfer after return", xfer, 0);
        check("R7", "phase normal", phase, 0);

        // R5: short loss of HOLD-1 samples is ignored
        hold_level(1'b0, HOLD - 1);
        hold_level(1'b1, 6);
        check("R5", "no switch on HOLD-1 run", opens_seen, 1);
        check("R5", "xfer after short run", xfer, 0);

        // R3 boundary: exactly HOLD samples commits
        hold_level(1'b0, HOLD);
        hold_level(1'b1, 6);
        check("R3", "switch on HOLD run", opens_seen, 2);

        // R4 boundary after that: settle back to normal
        hold_level(1'b1, 3 * HOLD);
        check("R4", "back to normal", phase, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule